// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two single-precision binary floating-point words. Each word is split into sign, biased exponent and fraction, with the hidden leading one restored. The significand of the operand with the smaller exponent is shifted right by the exponent gap. The two significands are then combined as signed integers. The magnitude of the sum is renormalized in one of two ways: by a single right shift when the sum carries out, or by a left shift of as many places as it has leading zeros, with the exponent adjusted by the same amount.

Subtraction uses the same adder: the sign bit of the second word is inverted before anything else happens. Some operand pairs skip the arithmetic and return one operand unchanged: a zero operand, or an exponent gap too wide for the smaller operand to matter. Subnormal inputs count as zero, results are truncated, and exponent overflow saturates to infinity. Traffic moves through a two-register pipeline with a valid/ready handshake on both sides. One operation can be accepted per cycle while the output is being consumed.

Top module: `fp_addsub`

## Requirements
- R1: Words use sign in bit 31, an 8-bit exponent biased by 127 in bits 30:23 and a 23-bit fraction in bits 22:0. in_op = 0 yields in_a + in_b, and in_op = 1 yields in_a - in_b, which is formed by inverting bit 31 of in_b and then adding.
- R2: An operand whose exponent field is 0 is zero, whatever its fraction. If in_b is zero the result is in_a bit for bit. Otherwise, if in_a is zero, the result is in_b with bit 31 inverted when in_op = 1.
- R3: When the exponent difference exceeds 24, the result is the operand with the larger exponent, unchanged (in_b with bit 31 inverted when in_op = 1).
- R4: The smaller-exponent significand is shifted right by the exponent difference, and the bits shifted out are discarded. No guard or sticky bits are kept, so the result magnitude is truncated.
- R5: A sum that is exactly zero gives 0x00000000.
- R6: A carry out of the significand add shifts the magnitude right by one place and adds one to the exponent.
- R7: A sum with leading zeros is shifted left until its top bit is one, and the exponent is lowered by the shift count.
- R8: A result exponent above 254 gives infinity: exponent field 255, fraction 0, and the sign of the sum.
- R9: A result exponent below 1 after normalization gives 0x00000000.
- R10: An operation is accepted on a rising edge where in_valid and in_ready are both high. With out_ready held high, its result is shown with out_valid two rising edges later. Results leave in order. While out_valid is high and out_ready is low, out_valid and out_data hold.
- R11: in_ready is low only when both pipeline registers are full and the output is not being taken. After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and op are offered |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_op | input | 1 | 0 = add, 1 = subtract |
| out_valid | output | 1 | out_data holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Result word |

## Verification
Two functions can coincide within a single operation: the one-place right shift on carry-out, and the saturation to infinity when that increment pushes the exponent past 254. Adding the largest finite value to itself, with both signs, provokes this, and the result is judged against exact infinity words. A stall and a fresh offer can also meet in one cycle. The bench holds out_ready low while three operations are offered back to back. It then requires in_ready to drop on the third offer, the first result to stay frozen, and all three results to appear in order once the stall is released.

// File: rtl/fp_addsub_pkg.sv
package fp_addsub_pkg;
  typedef enum logic {
    FP_OP_ADD = 1'b0,
    FP_OP_SUB = 1'b1
  } fp_op_e;
endpackage

// File: rtl/fp_lzc.sv
module fp_lzc #(
  parameter int W  = 24,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt
);
  // scan upward so the highest set bit is the last to write cnt
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fp_align_add.sv
module fp_align_add #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] opa,
  input  logic [EXP_W+MAN_W:0] opb,
  input  logic                 sub,
  output logic                 byp,
  output logic [EXP_W+MAN_W:0] byp_word,
  output logic                 sum_neg,
  output logic [MAN_W+1:0]     sum_mag,
  output logic [EXP_W-1:0]     sum_exp
);
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1;
  localparam int SUM_W  = SIG_W + 2;
  localparam logic [EXP_W-1:0] GAP_MAX = EXP_W'(SIG_W);

  logic [WORD_W-1:0]       opb_eff;
  logic [EXP_W-1:0]        ea, eb, gap;
  logic                    a_zero, b_zero, a_big;
  logic [SIG_W-1:0]        big_sig, small_sig, small_al;
  logic                    big_neg, small_neg;
  logic signed [SUM_W-1:0] big_s, small_s, sum, neg_sum;

  always_comb begin
    opb_eff = {opb[WORD_W-1] ^ sub, opb[WORD_W-2:0]};
    ea      = opa[WORD_W-2 -: EXP_W];
    eb      = opb[WORD_W-2 -: EXP_W];
    a_zero  = (ea == '0);
    b_zero  = (eb == '0);
    a_big   = (ea >= eb);
    gap     = a_big ? (ea - eb) : (eb - ea);

    if (a_big) begin
      big_sig   = {1'b1, opa[MAN_W-1:0]};
      big_neg   = opa[WORD_W-1];
      small_sig = {1'b1, opb[MAN_W-1:0]};
      small_neg = opb_eff[WORD_W-1];
      sum_exp   = ea;
    end else begin
      big_sig   = {1'b1, opb[MAN_W-1:0]};
      big_neg   = opb_eff[WORD_W-1];
      small_sig = {1'b1, opa[MAN_W-1:0]};
      small_neg = opa[WORD_W-1];
      sum_exp   = eb;
    end

    small_al = (gap >= GAP_MAX) ? '0 : (small_sig >> gap);

    big_s   = $signed({2'b00, big_sig});
    small_s = $signed({2'b00, small_al});
    if (big_neg)   big_s   = -big_s;
    if (small_neg) small_s = -small_s;

    sum     = big_s + small_s;
    neg_sum = -sum;
    sum_neg = sum[SUM_W-1];
    sum_mag = sum_neg ? neg_sum[SIG_W:0] : sum[SIG_W:0];

    // shortcut results: zero operand first, then a gap too wide to matter
    byp      = 1'b1;
    byp_word = opa;
    if (b_zero)              byp_word = opa;
    else if (a_zero)         byp_word = opb_eff;
    else if (gap > GAP_MAX)  byp_word = a_big ? opa : opb_eff;
    else                     byp      = 1'b0;
  end
endmodule

// File: rtl/fp_norm_pack.sv
module fp_norm_pack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 neg,
  input  logic [MAN_W+1:0]     mag,
  input  logic [EXP_W-1:0]     exp_in,
  output logic [EXP_W+MAN_W:0] word
);
  localparam int SIG_W = MAN_W + 1;
  localparam int CW    = $clog2(SIG_W + 1);
  localparam int XW    = EXP_W + 2;
  localparam logic signed [XW-1:0] EXP_TOP = XW'((1 << EXP_W) - 1);
  localparam logic signed [XW-1:0] EXP_ONE = XW'(1);

  logic [CW-1:0]        lz;
  logic [SIG_W-1:0]     low, shifted;
  logic signed [XW-1:0] base, lz_x, exp_x;
  logic [MAN_W-1:0]     frac;

  assign low = mag[SIG_W-1:0];

  fp_lzc #(.W(SIG_W), .CW(CW)) u_lzc (
    .din (low),
    .cnt (lz)
  );

  always_comb begin
    base    = $signed({2'b00, exp_in});
    lz_x    = $signed({{(XW-CW){1'b0}}, lz});
    shifted = low << lz;
    if (mag[SIG_W]) begin
      frac  = mag[MAN_W:1];
      exp_x = base + EXP_ONE;
    end else begin
      frac  = shifted[MAN_W-1:0];
      exp_x = base - lz_x;
    end

    if (mag == '0)             word = '0;
    else if (exp_x >= EXP_TOP) word = {neg, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (exp_x < EXP_ONE)  word = '0;
    else                       word = {neg, exp_x[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fp_addsub_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [EXP_W+MAN_W:0] in_a,
  input  logic [EXP_W+MAN_W:0] in_b,
  input  logic                 in_op,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [EXP_W+MAN_W:0] out_data
);
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int MAG_W  = MAN_W + 2;

  fp_op_e            op_e;
  logic              is_sub;
  logic              en1, en2;

  logic              a_byp, a_neg;
  logic [WORD_W-1:0] a_word;
  logic [MAG_W-1:0]  a_mag;
  logic [EXP_W-1:0]  a_exp;

  logic              s1_valid, s1_byp, s1_neg;
  logic [WORD_W-1:0] s1_word;
  logic [MAG_W-1:0]  s1_mag;
  logic [EXP_W-1:0]  s1_exp;

  logic [WORD_W-1:0] n_word;

  assign op_e     = fp_op_e'(in_op);
  assign is_sub   = (op_e == FP_OP_SUB);
  assign en2      = !out_valid || out_ready;
  assign en1      = !s1_valid || en2;
  assign in_ready = en1;

  fp_align_add #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .opa      (in_a),
    .opb      (in_b),
    .sub      (is_sub),
    .byp      (a_byp),
    .byp_word (a_word),
    .sum_neg  (a_neg),
    .sum_mag  (a_mag),
    .sum_exp  (a_exp)
  );

  fp_norm_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .neg    (s1_neg),
    .mag    (s1_mag),
    .exp_in (s1_exp),
    .word   (n_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (en1) s1_valid  <= in_valid;
      if (en2) out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en1 && in_valid) begin
      s1_byp  <= a_byp;
      s1_word <= a_word;
      s1_neg  <= a_neg;
      s1_mag  <= a_mag;
      s1_exp  <= a_exp;
    end
    if (en2 && s1_valid) begin
      out_data <= s1_byp ? s1_word : n_word;
    end
  end
endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data
);
  logic [2:0] occ;
  logic       acc, dlv;

  assign acc = in_valid && in_ready;
  assign dlv = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + {2'b00, acc} - {2'b00, dlv};
  end

  p_hold_valid_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid);

  p_hold_data_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_data));

  p_occ_bound_r10: assert property (@(posedge clk) disable iff (rst)
    occ <= 3'd2);

  p_no_orphan_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> occ != 3'd0);

  p_stall_cause_r11: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid && !out_ready);
endmodule

bind fp_addsub fp_addsub_chk #(.WORD_W(1 + EXP_W + MAN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/fp_addsub_tb.sv
module fp_addsub_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_op;
  logic [31:0] in_a, in_b;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;

  always #10 clk = ~clk;

  fp_addsub u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // one operation through an idle pipeline, output taken immediately
  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic op, input logic [31:0] expv,
                        input string tag);
    @(negedge clk);
    in_a = a; in_b = b; in_op = op; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, {tag, " latency R10"}, {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check(out_valid == 1'b1, {tag, " valid R10"}, {31'd0, out_valid}, 32'd1);
    check(out_data == expv, tag, out_data, expv);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_a = '0; in_b = '0; in_op = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 reset out_valid", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R11 reset in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_basic;
    run_op(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, "R1 R6 1+1");
    run_op(32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, "R1 3-1");
    run_op(32'h40000000, 32'hBF000000, 1'b0, 32'h3FC00000, "R1 2+-0.5");
    run_op(32'hC0400000, 32'h3F800000, 1'b0, 32'hC0000000, "R1 -3+1");
  endtask

  task automatic t_zero;
    run_op(32'h00000000, 32'h40490FDB, 1'b0, 32'h40490FDB, "R2 0+b");
    run_op(32'h00000000, 32'h40490FDB, 1'b1, 32'hC0490FDB, "R2 0-b");
    run_op(32'hBF800000, 32'h00000123, 1'b0, 32'hBF800000, "R2 subnormal b");
    run_op(32'h80000000, 32'h00000000, 1'b0, 32'h80000000, "R2 both zero");
    run_op(32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, "R5 1-1");
    run_op(32'hC0400000, 32'hC0400000, 1'b1, 32'h00000000, "R5 -3--3");
  endtask

  task automatic t_gap;
    run_op(32'h3F800000, 32'h4C000000, 1'b1, 32'hCC000000, "R3 gap25 sub");
    run_op(32'h4C000000, 32'h3F800000, 1'b0, 32'h4C000000, "R3 gap25 add");
    run_op(32'h3F800000, 32'h33FFFFFF, 1'b0, 32'h3F800000, "R4 gap24");
    run_op(32'h3F800000, 32'h34000000, 1'b0, 32'h3F800001, "R4 gap23");
  endtask

  task automatic t_norm;
    run_op(32'h3FC00000, 32'h3FA00000, 1'b1, 32'h3E800000, "R7 1.5-1.25");
    run_op(32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h34000000, "R7 R4 long shift");
  endtask

  task automatic t_range;
    run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, "R8 R6 +inf");
    run_op(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, "R8 -inf");
    run_op(32'h00800000, 32'h00C00000, 1'b1, 32'h00000000, "R9 flush");
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 32'h3F800000; in_b = 32'h3F800000; in_op = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_a = 32'h3FC00000; in_b = 32'h3FA00000; in_op = 1'b1;
    @(negedge clk);
    in_a = 32'h40000000; in_b = 32'hBF000000; in_op = 1'b0;
    check(in_ready == 1'b0, "R11 full stall", {31'd0, in_ready}, 32'd0);
    check(out_data == 32'h40000000, "R10 first result", out_data, 32'h40000000);
    @(negedge clk);
    check(in_ready == 1'b0, "R11 stall holds", {31'd0, in_ready}, 32'd0);
    check(out_valid == 1'b1 && out_data == 32'h40000000, "R10 data held",
          out_data, 32'h40000000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && out_data == 32'h3E800000, "R10 second in order",
          out_data, 32'h3E800000);
    @(negedge clk);
    check(out_valid == 1'b1 && out_data == 32'h3FC00000, "R10 third in order",
          out_data, 32'h3FC00000);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_basic;
    t_zero;
    t_gap;
    t_norm;
    t_range;
    t_stall;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule